// File: doc/BRIEF.md
# Wavefront Slot Allocator by Shader Stage

The allocator decides whether another wavefront may become resident in a shader array. It tracks how many resident wavefronts belong to each of three shader stages: vertex, geometry and pixel. It grants or refuses each new request. A request names its stage. It is granted only when that stage is below its own programmable ceiling and a shared pool of slots still has room. Occupancy is always counted in whole wavefronts. One wavefront carries 64 work items, but work items are never counted here.

A geometry-enable mode changes how the shared pool is divided. With geometry on, geometry wavefronts hold a reserved share of the pool, and vertex and pixel wavefronts split what is left. With geometry off, geometry requests are refused, and vertex and pixel wavefronts may fill the whole pool. A mode change waits until no geometry wavefront is resident.

A retire port frees one slot of a named stage each cycle. The per-stage counts and the total are presented as outputs.

Top module: `wave_slot_alloc`

## Requirements
- R1: After reset all counts are zero, geometry mode is on, no grant or error is raised, and the stage ceilings are pixel 144, vertex 36 and geometry 9.
- R2: The total of resident wavefronts never exceeds the pool size of 192. A request that would exceed it is refused.
- R3: A request is granted only while its stage count is below that stage's ceiling. Stage codes are 0 for vertex, 1 for geometry and 2 for pixel.
- R4: While geometry mode is on, a vertex or pixel request is granted only while the vertex count plus the pixel count is below 156.
- R5: While geometry mode is on, the geometry count never exceeds 36. While it is off, geometry requests are refused, and vertex plus pixel may reach 192.
- R6: The grant output is high in the cycle after a granted request. The stage count rises by one on the same clock edge.
- R7: A ceiling write selects vertex (0), geometry (1) or pixel (2) and applies from the next cycle. Select value 3 is ignored.
- R8: A granted request and a retire of the same stage in one cycle leave that stage's count unchanged.
- R9: A retire of a stage whose count is zero is ignored. The error output is high for the following cycle. A retire with stage code 3 is ignored and raises no error.
- R10: A requested mode change takes effect only on an edge where the geometry count is zero and no geometry grant is made. Until then the pending output is high and the mode holds.
- R11: A request with stage code 3 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one wavefront slot |
| alloc_stage | input | 2 | Stage of the request |
| alloc_grant | output | 1 | Previous cycle's request was granted |
| retire_req | input | 1 | Free one wavefront slot |
| retire_stage | input | 2 | Stage of the freed slot |
| retire_err | output | 1 | Previous cycle's retire hit an empty stage |
| cap_we | input | 1 | Write a stage ceiling |
| cap_sel | input | 2 | Ceiling being written |
| cap_val | input | CW | New ceiling value |
| geo_en_req | input | 1 | Requested geometry mode |
| geo_en | output | 1 | Current geometry mode |
| mode_pend | output | 1 | A requested mode change is waiting |
| cnt_vtx | output | CW | Resident vertex wavefronts |
| cnt_geo | output | CW | Resident geometry wavefronts |
| cnt_pix | output | CW | Resident pixel wavefronts |
| cnt_total | output | CW | Sum of all resident wavefronts |

## Verification
Every result is due one clock edge after its stimulus. The grant, the error flag, the counts and the ceilings all update on the edge that samples the request, and a mode change also takes one edge once its condition holds. The bench drives inputs on the falling edge and reads outputs shortly after the following rising edge, so each sample shows exactly one cycle's effect. Phases that fill a stage to a limit count the grants over a run of requests. They compare the total with the smaller of the remaining ceiling headroom and the remaining pool headroom.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [1:0] {
    ST_VTX  = 2'd0,
    ST_GEO  = 2'd1,
    ST_PIX  = 2'd2,
    ST_NONE = 2'd3
  } stage_e;
  localparam int NUM_STAGES = 3;
endpackage

// File: rtl/wsa_stage_counter.sv
module wsa_stage_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec_req,
  output logic [CW-1:0] cnt,
  output logic          dec_bad
);
  logic dec_ok;
  assign dec_ok  = dec_req && (cnt != '0);
  assign dec_bad = dec_req && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (inc && !dec_ok) cnt <= cnt + 1'b1;
    else if (dec_ok && !inc) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wsa_admit.sv
module wsa_admit
  import wsa_pkg::*;
#(
  parameter int POOL    = 192,
  parameter int GEO_RES = 36,
  parameter int CW      = 8
) (
  input  logic          req,
  input  logic [1:0]    stage,
  input  logic          geo_en,
  input  logic [CW-1:0] cnt_v,
  input  logic [CW-1:0] cnt_g,
  input  logic [CW-1:0] cnt_p,
  input  logic [CW-1:0] cap_v,
  input  logic [CW-1:0] cap_g,
  input  logic [CW-1:0] cap_p,
  output logic          ok
);
  localparam logic [CW+1:0] POOL_L = (CW+2)'(POOL);
  localparam logic [CW+1:0] VP_ON  = (CW+2)'(POOL - GEO_RES);
  localparam logic [CW-1:0] RES_L  = CW'(GEO_RES);

  logic [CW+1:0] vp, tot, vp_lim;
  logic          pool_room, stage_ok;

  assign vp        = (CW+2)'(cnt_v) + (CW+2)'(cnt_p);
  assign tot       = vp + (CW+2)'(cnt_g);
  assign vp_lim    = geo_en ? VP_ON : POOL_L;
  assign pool_room = tot < POOL_L;

  always_comb begin
    case (stage_e'(stage))
      ST_VTX:  stage_ok = (cnt_v < cap_v) && (vp < vp_lim);
      ST_PIX:  stage_ok = (cnt_p < cap_p) && (vp < vp_lim);
      ST_GEO:  stage_ok = geo_en && (cnt_g < cap_g) && (cnt_g < RES_L);
      default: stage_ok = 1'b0;
    endcase
  end

  assign ok = req && pool_room && stage_ok;
endmodule

// File: rtl/wsa_mode_ctl.sv
module wsa_mode_ctl #(
  parameter logic GEO_EN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic geo_empty,
  input  logic geo_inc,
  output logic geo_en,
  output logic pend
);
  assign pend = (want != geo_en);

  always_ff @(posedge clk) begin
    if (rst)                                geo_en <= GEO_EN_RST;
    else if (pend && geo_empty && !geo_inc) geo_en <= want;
  end
endmodule

// File: rtl/wave_slot_alloc.sv
module wave_slot_alloc
  import wsa_pkg::*;
#(
  parameter int   POOL        = 192,
  parameter int   GEO_RES     = 36,
  parameter int   CW          = 8,
  parameter int   CAP_VTX_RST = 36,
  parameter int   CAP_GEO_RST = 9,
  parameter int   CAP_PIX_RST = 144,
  parameter logic GEO_EN_RST  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic [1:0]    alloc_stage,
  output logic          alloc_grant,
  input  logic          retire_req,
  input  logic [1:0]    retire_stage,
  output logic          retire_err,
  input  logic          cap_we,
  input  logic [1:0]    cap_sel,
  input  logic [CW-1:0] cap_val,
  input  logic          geo_en_req,
  output logic          geo_en,
  output logic          mode_pend,
  output logic [CW-1:0] cnt_vtx,
  output logic [CW-1:0] cnt_geo,
  output logic [CW-1:0] cnt_pix,
  output logic [CW-1:0] cnt_total
);
  logic [CW-1:0] cap_q [NUM_STAGES];
  logic [CW-1:0] cnt   [NUM_STAGES];
  logic [NUM_STAGES-1:0] inc, dec, dec_bad;
  logic ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q[ST_VTX] <= CW'(CAP_VTX_RST);
      cap_q[ST_GEO] <= CW'(CAP_GEO_RST);
      cap_q[ST_PIX] <= CW'(CAP_PIX_RST);
    end else if (cap_we && cap_sel != ST_NONE) begin
      cap_q[cap_sel] <= cap_val;
    end
  end

  wsa_admit #(.POOL(POOL), .GEO_RES(GEO_RES), .CW(CW)) u_admit (
    .req(alloc_req), .stage(alloc_stage), .geo_en(geo_en),
    .cnt_v(cnt[ST_VTX]), .cnt_g(cnt[ST_GEO]), .cnt_p(cnt[ST_PIX]),
    .cap_v(cap_q[ST_VTX]), .cap_g(cap_q[ST_GEO]), .cap_p(cap_q[ST_PIX]),
    .ok(ok)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign inc[s] = ok && (alloc_stage == 2'(s));
    assign dec[s] = retire_req && (retire_stage == 2'(s));
    wsa_stage_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc[s]), .dec_req(dec[s]),
      .cnt(cnt[s]), .dec_bad(dec_bad[s])
    );
  end

  wsa_mode_ctl #(.GEO_EN_RST(GEO_EN_RST)) u_mode (
    .clk(clk), .rst(rst), .want(geo_en_req),
    .geo_empty(cnt[ST_GEO] == '0), .geo_inc(inc[ST_GEO]),
    .geo_en(geo_en), .pend(mode_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_grant <= 1'b0;
      retire_err  <= 1'b0;
    end else begin
      alloc_grant <= ok;
      retire_err  <= |dec_bad;
    end
  end

  assign cnt_vtx   = cnt[ST_VTX];
  assign cnt_geo   = cnt[ST_GEO];
  assign cnt_pix   = cnt[ST_PIX];
  assign cnt_total = cnt[ST_VTX] + cnt[ST_GEO] + cnt[ST_PIX];
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int POOL    = 192,
  parameter int GEO_RES = 36,
  parameter int CW      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_req,
  input logic [1:0]    alloc_stage,
  input logic          alloc_grant,
  input logic          retire_req,
  input logic [1:0]    retire_stage,
  input logic          retire_err,
  input logic          geo_en,
  input logic [CW-1:0] cnt_vtx,
  input logic [CW-1:0] cnt_geo,
  input logic [CW-1:0] cnt_pix,
  input logic [CW-1:0] cnt_total,
  input logic [CW-1:0] cap_v,
  input logic [CW-1:0] cap_g,
  input logic [CW-1:0] cap_p
);
  localparam logic [CW-1:0] POOL_L = CW'(POOL);
  localparam logic [CW-1:0] RES_L  = CW'(GEO_RES);
  localparam logic [CW:0]   VP_ON  = (CW+1)'(POOL - GEO_RES);

  function automatic logic [CW-1:0] pick(input logic [1:0] s, input logic [CW-1:0] v,
                                         input logic [CW-1:0] g, input logic [CW-1:0] p);
    case (s)
      2'd0:    pick = v;
      2'd1:    pick = g;
      default: pick = p;
    endcase
  endfunction

  logic [CW:0] vp;
  assign vp = (CW+1)'(cnt_vtx) + (CW+1)'(cnt_pix);

  AST_POOL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_total <= POOL_L);  // R2
  AST_GRANT_CAP: assert property (@(posedge clk) disable iff (rst)
    alloc_grant |-> pick($past(alloc_stage), $past(cnt_vtx), $past(cnt_geo), $past(cnt_pix))
                    < pick($past(alloc_stage), $past(cap_v), $past(cap_g), $past(cap_p)));  // R3
  AST_VP_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (alloc_grant && $past(geo_en) && $past(alloc_stage) != 2'd1) |-> ($past(vp) < VP_ON));  // R4
  AST_GEO_RESERVE: assert property (@(posedge clk) disable iff (rst)
    geo_en |-> cnt_geo <= RES_L);  // R5
  AST_GEO_OFF: assert property (@(posedge clk) disable iff (rst)
    !geo_en |-> cnt_geo == '0);  // R5
  AST_GRANT_RISE: assert property (@(posedge clk) disable iff (rst)
    (alloc_grant && !($past(retire_req) && $past(retire_stage) == $past(alloc_stage)))
      |-> pick($past(alloc_stage), cnt_vtx, cnt_geo, cnt_pix)
          == pick($past(alloc_stage), $past(cnt_vtx), $past(cnt_geo), $past(cnt_pix)) + 1'b1);  // R6
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    retire_err |-> pick($past(retire_stage), $past(cnt_vtx), $past(cnt_geo), $past(cnt_pix)) == '0);  // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_geo) != '0) |-> geo_en == $past(geo_en));  // R10
  AST_NO_STAGE3: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && alloc_stage == 2'd3) |=> !alloc_grant);  // R11
endmodule

bind wave_slot_alloc wsa_checker #(.POOL(POOL), .GEO_RES(GEO_RES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_stage(alloc_stage),
  .alloc_grant(alloc_grant), .retire_req(retire_req), .retire_stage(retire_stage),
  .retire_err(retire_err), .geo_en(geo_en), .cnt_vtx(cnt_vtx), .cnt_geo(cnt_geo),
  .cnt_pix(cnt_pix), .cnt_total(cnt_total),
  .cap_v(cap_q[0]), .cap_g(cap_q[1]), .cap_p(cap_q[2])
);

// File: tb/wave_slot_alloc_test.sv
module wave_slot_alloc_test;
  localparam int CW = 8;
  localparam int POOL = 192, RES = 36;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_req = 0, retire_req = 0, cap_we = 0, geo_en_req = 1;
  logic [1:0] alloc_stage = 0, retire_stage = 0, cap_sel = 0;
  logic [CW-1:0] cap_val = 0;
  logic alloc_grant, retire_err, geo_en, mode_pend;
  logic [CW-1:0] cnt_vtx, cnt_geo, cnt_pix, cnt_total;

  int total = 0, bad = 0;
  int grants;

  always #2.5 clk = ~clk;

  wave_slot_alloc uut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_stage(alloc_stage),
    .alloc_grant(alloc_grant), .retire_req(retire_req), .retire_stage(retire_stage),
    .retire_err(retire_err), .cap_we(cap_we), .cap_sel(cap_sel), .cap_val(cap_val),
    .geo_en_req(geo_en_req), .geo_en(geo_en), .mode_pend(mode_pend),
    .cnt_vtx(cnt_vtx), .cnt_geo(cnt_geo), .cnt_pix(cnt_pix), .cnt_total(cnt_total)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample just after the next rising edge
  task automatic cyc(input logic a, input logic [1:0] as, input logic r, input logic [1:0] rs);
    @(negedge clk);
    alloc_req = a; alloc_stage = as; retire_req = r; retire_stage = rs;
    @(posedge clk); #1;
    @(negedge clk);
    alloc_req = 0; retire_req = 0;
  endtask

  task automatic burst(input logic [1:0] st, input int n);
    grants = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1, st, 0, 0);
      if (alloc_grant) grants++;
    end
  endtask

  task automatic write_cap(input logic [1:0] sel, input int v);
    @(negedge clk);
    cap_we = 1; cap_sel = sel; cap_val = CW'(v);
    @(negedge clk);
    cap_we = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1 cnt_total", cnt_total, 0);
    chk("R1 geo_en", geo_en, 1);
    chk("R1 grant", alloc_grant, 0);
    chk("R1 err", retire_err, 0);

    cyc(0, 0, 1, 2);
    chk("R9 err on empty retire", retire_err, 1);
    chk("R9 pix stays", cnt_pix, 0);
    cyc(0, 0, 1, 3);
    chk("R9 stage3 retire no err", retire_err, 0);

    cyc(1, 2, 0, 0);
    chk("R6 grant next cycle", alloc_grant, 1);
    chk("R6 pix count rose", cnt_pix, 1);
    burst(2, 149);
    chk("R3 pixel grants to cap", grants, 144 - 1);
    chk("R1 R3 pix at cap", cnt_pix, 144);

    burst(0, 40);
    chk("R4 vertex limited by split", grants, (POOL - RES) - 144);
    burst(1, 12);
    chk("R3 geo cap 9", grants, 9);

    write_cap(1, 40);
    burst(1, 40);
    chk("R7 R5 geo to reserve", grants, RES - 9);
    chk("R2 total full", cnt_total, POOL);
    burst(2, 1);
    chk("R2 pool full denies", grants, 0);

    cyc(0, 0, 1, 2);
    chk("R9 normal retire no err", retire_err, 0);
    cyc(1, 2, 1, 2);
    chk("R8 grant with retire", alloc_grant, 1);
    chk("R8 pix unchanged", cnt_pix, 143);

    @(negedge clk); geo_en_req = 0;
    @(posedge clk); #1;
    chk("R10 mode held", geo_en, 1);
    chk("R10 pending", mode_pend, 1);
    for (int i = 0; i < RES; i++) cyc(0, 0, 1, 1);
    chk("R10 still held at drain", geo_en, 1);
    @(posedge clk); #1;
    chk("R10 mode off", geo_en, 0);
    chk("R10 pend clear", mode_pend, 0);

    burst(1, 3);
    chk("R5 geo refused when off", grants, 0);
    burst(0, 30);
    chk("R5 vertex past split", grants, 36 - 12);
    burst(2, 5);
    chk("R3 pixel cap", grants, 1);
    write_cap(3, 0);
    burst(2, 1);
    chk("R7 sel3 ignored pix", grants, 0);
    write_cap(0, 60);
    burst(0, 30);
    chk("R2 R5 vertex to full pool", grants, POOL - 180);
    chk("R2 total", cnt_total, POOL);

    burst(3, 2);
    chk("R11 stage3 refused", grants, 0);

    @(negedge clk); geo_en_req = 1;
    @(posedge clk); #1;
    chk("R10 enable when empty", geo_en, 1);
    cyc(0, 0, 1, 0);
    burst(0, 1);
    chk("R4 split applies on enable", grants, 0);
    burst(1, 1);
    chk("R5 geo after enable", grants, 1);
    chk("R2 total back full", cnt_total, POOL);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule